// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external controller read and write a bank of control registers over a four-wire serial link: an active-low select, a serial clock, a data input and a data output. Each transaction is a fixed 16-bit frame sent most significant bit first. It carries a direction flag, a spare bit, a 6-bit register index and an 8-bit value. A write takes effect only when the select line is released after a full frame. A read returns the selected register on the output line during the second half of the frame.

The same register bank is also exposed on a parallel port in the system clock domain. Surrounding logic reads it combinationally and can write single registers. The serial lines are taken to be synchronous to the system clock and are oversampled there. Edges of the serial clock and of the select line are found by comparing each line with its value one cycle earlier. Synchronising the serial lines is outside this block.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset every register reads 0 on the parallel port and the serial output is 0.
- R2: A frame is shifted in on rising serial-clock edges, most significant bit first. Bit 15 is the direction (0 = write, 1 = read), bit 14 is spare, bits 13:8 are the register index and bits 7:0 are the value. A write frame stores the value into the indexed register.
- R3: A write frame does not change the register while select is still low, even after all 16 clocks. The register takes the new value once select rises.
- R4: If select rises after fewer than 16 serial clocks, no register changes.
- R5: Serial clocks after the 16th, while select stays low, are ignored. The stored value comes from the first 16 bits.
- R6: In a read frame, the output changes on falling serial-clock edges. On rising edges 9 to 16 it presents the indexed register, most significant bit first.
- R7: A read frame leaves every register unchanged, whatever its value field holds.
- R8: The serial output is 0 while select is high, during the first 8 clocks of any frame, and throughout write frames.
- R9: The spare bit 14 has no effect on either a write or a read.
- R10: A parallel write updates the addressed register. Serial reads and the parallel read port both see the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state and oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| par_we | input | 1 | Parallel write enable |
| par_addr | input | 6 | Parallel register index (write and read) |
| par_wdata | input | 8 | Parallel write value |
| par_rdata | output | 8 | Value of register at par_addr |

## Verification
The bound checker watches four things on every cycle. The output must stay quiet while select is high and during the header. The bank must not change while a frame is still open. A short frame must not write, and a read frame must not write. Its own bit counter sets the conditions for these checks. The bench scenarios cover what needs a reference model: the bit order and values returned by reads, the data actually stored by full, over-long and spare-bit frames, and the interaction with parallel writes. A monitor compares each returned read byte against a queue of expected values.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
   typedef enum logic {SDO_IDLE_LOW, SDO_IDLE_HIZ} sdo_idle_e;

   function automatic int frame_bits(input int aw, input int dw);
      return 2 + aw + dw;
   endfunction
endpackage

// File: rtl/spi_rb_edges.sv
module spi_rb_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic csn,
   output logic sck_rise,
   output logic sck_fall,
   output logic csn_rise
);
   logic sck_q, csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         csn_q <= 1'b1;
      end else begin
         sck_q <= sck;
         csn_q <= csn;
      end
   end

   assign sck_rise = sck & ~sck_q & ~csn;
   assign sck_fall = ~sck & sck_q & ~csn;
   assign csn_rise = csn & ~csn_q;
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   localparam int FL = spi_rb_pkg::frame_bits(ADDR_W, DATA_W),
   localparam int HL = 2 + ADDR_W,
   localparam int CW = $clog2(FL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sdi,
   input  logic              sck_rise,
   input  logic              csn_rise,
   output logic [CW-1:0]     bit_cnt,
   output logic              hdr_rd,
   output logic [ADDR_W-1:0] hdr_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic [FL-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (csn) begin
         bit_cnt <= '0;
      end else if (sck_rise && (bit_cnt < CW'(FL))) begin
         shreg   <= {shreg[FL-2:0], sdi};
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   // header view: valid once HL bits have arrived
   assign hdr_rd   = shreg[HL-1];
   assign hdr_addr = shreg[ADDR_W-1:0];

   // commit view: valid once the full frame has arrived
   assign wr_en   = csn_rise && (bit_cnt == CW'(FL)) && !shreg[FL-1];
   assign wr_addr = shreg[DATA_W+ADDR_W-1:DATA_W];
   assign wr_data = shreg[DATA_W-1:0];
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
   parameter int DATA_W = 8,
   parameter int HL     = 8,
   parameter int FL     = 16,
   parameter int CW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sck_fall,
   input  logic [CW-1:0]     bit_cnt,
   input  logic              hdr_rd,
   input  logic [DATA_W-1:0] rd_data,
   output logic              tx_act,
   output logic              tx_bit
);
   logic [DATA_W-1:0] txsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txsh   <= '0;
         tx_act <= 1'b0;
      end else if (csn) begin
         tx_act <= 1'b0;
      end else if (sck_fall) begin
         if (bit_cnt == CW'(HL) && hdr_rd) begin
            txsh   <= rd_data;
            tx_act <= 1'b1;
         end else if (bit_cnt >= CW'(FL)) begin
            tx_act <= 1'b0;
         end else if (tx_act) begin
            txsh <= {txsh[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign tx_bit = txsh[DATA_W-1];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_we,
   input  logic [ADDR_W-1:0] s_waddr,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              p_we,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [DATA_W-1:0] p_wdata,
   input  logic [ADDR_W-1:0] s_raddr,
   output logic [DATA_W-1:0] s_rdata,
   output logic [DATA_W-1:0] p_rdata
);
   logic [DATA_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (s_we && s_waddr == ADDR_W'(i))
            regs[i] <= s_wdata;   // serial commit wins a same-cycle clash
         else if (p_we && p_addr == ADDR_W'(i))
            regs[i] <= p_wdata;
      end
   end

   always_comb begin
      s_rdata = '0;
      p_rdata = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (s_raddr == ADDR_W'(k)) s_rdata = regs[k];
         if (p_addr  == ADDR_W'(k)) p_rdata = regs[k];
      end
   end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 64,
   parameter spi_rb_pkg::sdo_idle_e IDLE_MODE = spi_rb_pkg::SDO_IDLE_LOW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   input  logic              par_we,
   input  logic [ADDR_W-1:0] par_addr,
   input  logic [DATA_W-1:0] par_wdata,
   output logic [DATA_W-1:0] par_rdata
);
   localparam int FL = spi_rb_pkg::frame_bits(ADDR_W, DATA_W);
   localparam int HL = 2 + ADDR_W;
   localparam int CW = $clog2(FL + 1);

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      initial $fatal(1, "NUM_REGS must be in 1..2**ADDR_W");
   end
   if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_width
      initial $fatal(1, "DATA_W must be >= 2 and ADDR_W >= 1");
   end

   logic              sck_rise, sck_fall, csn_rise;
   logic [CW-1:0]     bit_cnt;
   logic              hdr_rd, wr_en, tx_act, tx_bit;
   logic [ADDR_W-1:0] hdr_addr, wr_addr;
   logic [DATA_W-1:0] wr_data, rd_data;

   spi_rb_edges u_edges (
      .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .csn_rise(csn_rise)
   );

   spi_rb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .csn(csn), .sdi(sdi),
      .sck_rise(sck_rise), .csn_rise(csn_rise),
      .bit_cnt(bit_cnt), .hdr_rd(hdr_rd), .hdr_addr(hdr_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   spi_rb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .s_we(wr_en), .s_waddr(wr_addr), .s_wdata(wr_data),
      .p_we(par_we), .p_addr(par_addr), .p_wdata(par_wdata),
      .s_raddr(hdr_addr), .s_rdata(rd_data), .p_rdata(par_rdata)
   );

   spi_rb_tx #(.DATA_W(DATA_W), .HL(HL), .FL(FL), .CW(CW)) u_tx (
      .clk(clk), .rst_n(rst_n), .csn(csn), .sck_fall(sck_fall),
      .bit_cnt(bit_cnt), .hdr_rd(hdr_rd), .rd_data(rd_data),
      .tx_act(tx_act), .tx_bit(tx_bit)
   );

   if (IDLE_MODE == spi_rb_pkg::SDO_IDLE_HIZ) begin : g_sdo_hiz
      assign sdo = tx_act ? tx_bit : 1'bz;
   end else begin : g_sdo_low
      assign sdo = tx_act & tx_bit;
   end
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csn,
   input logic              sck,
   input logic              sdi,
   input logic              sdo,
   input logic              par_we,
   input logic [ADDR_W-1:0] par_addr,
   input logic [DATA_W-1:0] par_rdata
);
   localparam int FL = 2 + ADDR_W + DATA_W;
   localparam int HL = 2 + ADDR_W;
   localparam int CW = $clog2(FL + 1);

   logic          sck_q;
   logic [CW-1:0] n_bits;
   logic          rd_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         n_bits  <= '0;
         rd_flag <= 1'b0;
      end else begin
         sck_q <= sck;
         if (csn) begin
            n_bits <= '0;
         end else if (sck && !sck_q && n_bits < CW'(FL)) begin
            if (n_bits == '0) rd_flag <= sdi;
            n_bits <= n_bits + 1'b1;
         end
      end
   end

   AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (csn && $past(csn)) |-> (sdo !== 1'b1)); // R8

   AST_SDO_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn && n_bits < CW'(HL)) |-> (sdo !== 1'b1)); // R8

   AST_NO_MIDFRAME_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn && $past(!csn) && !$past(par_we) && $stable(par_addr)) |-> $stable(par_rdata)); // R3

   AST_SHORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(csn) && n_bits < CW'(FL) && !par_we) |=> (!$stable(par_addr) || $stable(par_rdata))); // R4

   AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(csn) && rd_flag && !par_we) |=> (!$stable(par_addr) || $stable(par_rdata))); // R7
endmodule

bind spi_regbank_slave spi_rb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .sdi(sdi), .sdo(sdo),
   .par_we(par_we), .par_addr(par_addr), .par_rdata(par_rdata)
);

// File: tb/spi_regbank_slave_tb.sv
module spi_regbank_slave_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csn = 1'b1;
   logic       sck = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo;
   logic       par_we = 1'b0;
   logic [5:0] par_addr = '0;
   logic [7:0] par_wdata = '0;
   logic [7:0] par_rdata;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] mdl [64];
   logic [7:0] exp_q [$];

   always #5 clk = ~clk;

   spi_regbank_slave u_dut (
      .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .sdi(sdi), .sdo(sdo),
      .par_we(par_we), .par_addr(par_addr), .par_wdata(par_wdata),
      .par_rdata(par_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (4) @(negedge clk);
   endtask

   // parallel-port check of one register against the model
   task automatic pchk(input logic [5:0] a, input string req);
      @(negedge clk);
      par_addr = a;
      #1;
      chk(par_rdata === mdl[a], req, par_rdata, mdl[a]);
   endtask

   task automatic pwrite(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      par_we = 1'b1; par_addr = a; par_wdata = d;
      @(negedge clk);
      par_we = 1'b0;
      mdl[a] = d;
   endtask

   // driver: one serial frame of nclk clocks; reads push the expected byte
   task automatic spi_xfer(input logic rw, input logic rsv, input logic [5:0] a,
                           input logic [7:0] d, input int nclk, input bit mid_check);
      logic [15:0] w;
      w = {rw, rsv, a, d};
      if (rw && nclk >= 16) exp_q.push_back(mdl[a]);
      @(negedge clk);
      csn = 1'b0;
      half();
      for (int i = 0; i < nclk; i++) begin
         sdi = (i < 16) ? w[15-i] : 1'b1;
         half();
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
      half();
      if (mid_check) begin
         par_addr = a;
         #1;
         chk(par_rdata === mdl[a], "R3 before select rises", par_rdata, mdl[a]);
      end
      csn = 1'b1;
      sdi = 1'b0;
      half();
      if (nclk >= 16 && !rw) mdl[a] = d;
   endtask

   // monitor: reassembles read bytes from sdo and scores them
   int         mbits = 0;
   logic       mrd = 1'b0;
   logic [7:0] cap = '0;

   always @(negedge csn) begin
      mbits = 0;
      mrd = 1'b0;
   end

   always @(posedge sck) begin
      if (!csn) begin
         mbits++;
         if (mbits == 1) mrd = sdi;
         if (mrd && mbits >= 9 && mbits <= 16)
            cap = {cap[6:0], sdo};
         else
            chk(sdo === 1'b0, "R8 output quiet", sdo, 0);
      end
   end

   always @(posedge csn) begin
      if (mrd && mbits >= 16) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected read", cap, 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(cap === e, "R6 read data", cap, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sdo === 1'b0, "R1 sdo after reset", sdo, 0);
      pchk(6'd0,  "R1 reset value");
      pchk(6'd17, "R1 reset value");
      pchk(6'd63, "R1 reset value");

      // R2 plain write, then R6 read back
      spi_xfer(1'b0, 1'b0, 6'd5, 8'h3A, 16, 1'b0);
      pchk(6'd5, "R2 write stored");
      spi_xfer(1'b1, 1'b0, 6'd5, 8'h00, 16, 1'b0);

      // R3 no update until select rises
      spi_xfer(1'b0, 1'b0, 6'd63, 8'hC3, 16, 1'b1);
      pchk(6'd63, "R3 after select rises");
      spi_xfer(1'b0, 1'b0, 6'd0, 8'h81, 16, 1'b0);
      pchk(6'd0, "R2 write index 0");
      spi_xfer(1'b1, 1'b0, 6'd0, 8'h00, 16, 1'b0);
      spi_xfer(1'b1, 1'b0, 6'd63, 8'h00, 16, 1'b0);

      // R4 short frames do nothing
      spi_xfer(1'b0, 1'b0, 6'd5, 8'h00, 10, 1'b0);
      pchk(6'd5, "R4 short frame 10");
      spi_xfer(1'b0, 1'b0, 6'd5, 8'hFF, 15, 1'b0);
      pchk(6'd5, "R4 short frame 15");

      // R5 clocks past the 16th ignored
      spi_xfer(1'b0, 1'b0, 6'd9, 8'h5C, 20, 1'b0);
      pchk(6'd9, "R5 extra clocks");

      // R9 spare bit set on write and read
      spi_xfer(1'b0, 1'b1, 6'd12, 8'h66, 16, 1'b0);
      pchk(6'd12, "R9 spare bit write");
      spi_xfer(1'b1, 1'b1, 6'd12, 8'h00, 16, 1'b0);

      // R7 read with non-zero data field leaves bank alone
      spi_xfer(1'b1, 1'b0, 6'd5, 8'hFF, 16, 1'b0);
      pchk(6'd5, "R7 read keeps value");
      pchk(6'd63, "R7 read keeps others");

      // R10 parallel write seen by both read paths
      pwrite(6'd40, 8'hE7);
      pchk(6'd40, "R10 parallel write");
      spi_xfer(1'b1, 1'b0, 6'd40, 8'h00, 16, 1'b0);

      half();
      chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule